// File: doc/BRIEF.md
# Zero-Turnaround Late-Write Synchronous SRAM

This block is a synchronous static memory with a bus that never needs an idle cycle between a read and a write. Each rising clock edge can take a new command: an address with a direction, or a continuation of the current four-beat burst. The data for a command travels on the shared data bus in a fixed slot after the command edge. That slot lies one edge later in flow-through mode and two edges later in pipelined mode. A read's output and a write's input land in the same slot position, so reads and writes can alternate on every cycle without the bus ever being driven from both sides.

Because write data arrives late, the memory array is updated only in the data slot. In pipelined mode a read issued one cycle after a write to the same word would otherwise see the old array contents. The block therefore merges the in-flight write data, lane by lane, into the read result. Bytes are 9 bits wide, with one write enable per lane. Three chip enables with mixed polarities select the device. An active-low output enable gates the data drivers without waiting for a clock edge. Slot timing on the bus is fixed, so the bus has no valid/ready handshake and no back-pressure. A command is accepted on every edge, and the data for it must be present, or be taken, in its slot.

Top module: `ztsram_top`

## Requirements
- R1: A new command (adv = 0) is accepted only when cs_a_n = 0, cs_b = 1 and cs_c_n = 0. With any one of these inactive, the cycle carries no transfer.
- R2: A read's data is driven on dq_out with dq_oe = 1 in the cycle before the first edge after the command edge when pipe_mode = 0, and in the cycle before the second edge when pipe_mode = 1.
- R3: Write data is taken from dq_in at the first edge after the command edge when pipe_mode = 0, and at the second edge when pipe_mode = 1. dq_oe stays 0 in that slot.
- R4: Reads and writes may be issued on consecutive edges in any mix, with no idle cycle, and every transfer completes in its own slot.
- R5: A read of a word whose write is still waiting for its data returns that write's data on the lanes it enables, and the older contents on the other lanes.
- R6: Lane j covers dq bits [9j+8:9j]. A write changes only the lanes whose lane_we bit is 1.
- R7: With adv = 1 the burst started by the last accepted command goes on, with the same direction, for beats 1, 2, 3 (then wrapping). With lin_order = 1 the beat address keeps the upper address bits and uses (start[1:0] + beat) mod 4 as its two low bits.
- R8: With lin_order = 0 the beat address uses start[1:0] XOR beat as its two low bits.
- R9: A deselect cycle leaves dq_oe = 0 in its data slot, while writes issued earlier still take their data in their own slots.
- R10: oe_n = 1 forces dq_oe = 0 at once, whatever the synchronous state.
- R11: After reset dq_oe = 0 and no burst is active, so adv = 1 produces no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all inputs sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| pipe_mode | input | 1 | 1 = pipelined, 0 = flow-through (static) |
| lin_order | input | 1 | 1 = linear burst order, 0 = interleaved (static) |
| cs_a_n | input | 1 | Chip enable, active low |
| cs_b | input | 1 | Chip enable, active high |
| cs_c_n | input | 1 | Chip enable, active low |
| adv | input | 1 | 1 = continue burst, 0 = load new command |
| we | input | 1 | 1 = write, 0 = read (on load cycles) |
| addr | input | AW | Word address (on load cycles) |
| lane_we | input | NL | Per-lane write enables, sampled with each command or beat |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_in | input | NL*BW | Write data bus, input side |
| dq_out | output | NL*BW | Read data bus, output side |
| dq_oe | output | 1 | Drive enable for dq_out |

## Verification
On every cycle the assertions check the drive pattern of the bus. The output enable blocks the drivers at once. A selected read drives in its slot in each mode. Write slots and deselect slots stay undriven. Data values cannot be checked that way: forwarding of pending writes, lane merging and the two burst orders show only in the bench's scenarios. There, a reference memory updated in command order predicts every read word, including reads that follow a write to the same word on the very next edge.

// File: rtl/ztsram_pkg.sv
package ztsram_pkg;
  // Low two address bits of a burst beat.
  function automatic logic [1:0] beat_addr(input logic [1:0] start,
                                           input logic [1:0] beat,
                                           input logic       lin);
    return lin ? 2'(start + beat) : (start ^ beat);
  endfunction
endpackage

// File: rtl/ztsram_cmd.sv
module ztsram_cmd #(
  parameter int AW = 6,
  parameter int NL = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lin,
  input  logic          sel,
  input  logic          adv,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [NL-1:0] lane_we,
  output logic          op_vld,
  output logic          op_wr,
  output logic [AW-1:0] op_addr,
  output logic [NL-1:0] op_lanes
);
  import ztsram_pkg::*;

  logic          act_q, wr_q;
  logic [AW-1:0] base_q;
  logic [1:0]    cnt_q, cnt_nx;

  assign cnt_nx = cnt_q + 2'd1;

  always_comb begin
    op_lanes = lane_we;
    if (!adv) begin
      op_vld  = sel;
      op_wr   = we;
      op_addr = addr;
    end else begin
      op_vld  = act_q;
      op_wr   = wr_q;
      op_addr = {base_q[AW-1:2], beat_addr(base_q[1:0], cnt_nx, lin)};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      base_q <= '0;
      cnt_q  <= '0;
    end else if (!adv) begin
      act_q  <= sel;
      wr_q   <= we;
      base_q <= addr;
      cnt_q  <= '0;
    end else if (act_q) begin
      cnt_q  <= cnt_nx;
    end
  end
endmodule

// File: rtl/ztsram_stage.sv
module ztsram_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/ztsram_array.sv
module ztsram_array #(
  parameter int AW = 6,
  parameter int NL = 2,
  parameter int BW = 9
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [NL-1:0]    wr_lanes,
  input  logic [NL*BW-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [NL*BW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;
  localparam int DW    = NL * BW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int j = 0; j < NL; j++) begin
        if (wr_lanes[j]) mem[wr_addr][j*BW +: BW] <= wr_data[j*BW +: BW];
      end
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/ztsram_top.sv
module ztsram_top #(
  parameter int AW = 6,
  parameter int NL = 2,
  parameter int BW = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pipe_mode,
  input  logic             lin_order,
  input  logic             cs_a_n,
  input  logic             cs_b,
  input  logic             cs_c_n,
  input  logic             adv,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [NL-1:0]    lane_we,
  input  logic             oe_n,
  input  logic [NL*BW-1:0] dq_in,
  output logic [NL*BW-1:0] dq_out,
  output logic             dq_oe
);
  localparam int DW   = NL * BW;
  localparam int OPW  = 2 + AW + NL;
  localparam int NSTG = 2;

  logic          sel;
  logic          c_vld, c_wr;
  logic [AW-1:0] c_addr;
  logic [NL-1:0] c_lanes;

  assign sel = !cs_a_n && cs_b && !cs_c_n;

  ztsram_cmd #(.AW(AW), .NL(NL)) u_cmd (
    .clk(clk), .rst_n(rst_n), .lin(lin_order), .sel(sel), .adv(adv),
    .we(we), .addr(addr), .lane_we(lane_we),
    .op_vld(c_vld), .op_wr(c_wr), .op_addr(c_addr), .op_lanes(c_lanes)
  );

  // Command delay line: stage 1 = previous edge, stage 2 = two edges back.
  logic [OPW-1:0] stg [NSTG+1];
  assign stg[0] = {c_vld, c_wr, c_addr, c_lanes};

  for (genvar g = 0; g < NSTG; g++) begin : g_stg
    ztsram_stage #(.W(OPW)) u_stg (
      .clk(clk), .rst_n(rst_n), .d(stg[g]), .q(stg[g+1])
    );
  end

  logic          s1_vld, s1_wr, s2_vld, s2_wr;
  logic [AW-1:0] s1_addr, s2_addr;
  logic [NL-1:0] s1_lanes, s2_lanes;

  assign {s1_vld, s1_wr, s1_addr, s1_lanes} = stg[1];
  assign {s2_vld, s2_wr, s2_addr, s2_lanes} = stg[2];

  // Late-write commit: one edge after the command in flow mode, two in pipe mode.
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [NL-1:0] wr_lanes;
  logic [DW-1:0] rd_data;

  always_comb begin
    if (pipe_mode) begin
      wr_en    = s2_vld && s2_wr;
      wr_addr  = s2_addr;
      wr_lanes = s2_lanes;
    end else begin
      wr_en    = s1_vld && s1_wr;
      wr_addr  = s1_addr;
      wr_lanes = s1_lanes;
    end
  end

  ztsram_array #(.AW(AW), .NL(NL), .BW(BW)) u_mem (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_lanes(wr_lanes),
    .wr_data(dq_in), .rd_addr(s1_addr), .rd_data(rd_data)
  );

  // Forward a write whose data is arriving now into the read being registered.
  logic          fwd_hit;
  logic [DW-1:0] rd_merged;

  assign fwd_hit = pipe_mode && s2_vld && s2_wr && (s2_addr == s1_addr);

  for (genvar j = 0; j < NL; j++) begin : g_fwd
    assign rd_merged[j*BW +: BW] = (fwd_hit && s2_lanes[j]) ? dq_in[j*BW +: BW]
                                                            : rd_data[j*BW +: BW];
  end

  logic          out_vld;
  logic [DW-1:0] out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      out_q   <= '0;
    end else begin
      out_vld <= s1_vld && !s1_wr;
      if (s1_vld && !s1_wr) out_q <= rd_merged;
    end
  end

  logic drive;
  assign drive  = pipe_mode ? out_vld : (s1_vld && !s1_wr);
  assign dq_out = pipe_mode ? out_q : rd_data;
  assign dq_oe  = drive && !oe_n;
endmodule

// File: rtl/ztsram_chk.sv
module ztsram_chk #(
  parameter int AW = 6,
  parameter int NL = 2,
  parameter int BW = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pipe_mode,
  input logic             lin_order,
  input logic             cs_a_n,
  input logic             cs_b,
  input logic             cs_c_n,
  input logic             adv,
  input logic             we,
  input logic [AW-1:0]    addr,
  input logic [NL-1:0]    lane_we,
  input logic             oe_n,
  input logic [NL*BW-1:0] dq_in,
  input logic [NL*BW-1:0] dq_out,
  input logic             dq_oe
);
  logic selected;
  assign selected = !cs_a_n && cs_b && !cs_c_n;

  p_oe_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_oe);

  p_flow_read_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && !adv && selected && !we) |=> (dq_oe || oe_n));

  p_pipe_read_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && !adv && selected && !we) |=> ##1 (dq_oe || oe_n));

  p_flow_write_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && !adv && selected && we) |=> !dq_oe);

  p_pipe_write_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && !adv && selected && we) |=> ##1 !dq_oe);

  p_flow_desel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && !adv && !selected) |=> !dq_oe);

  p_pipe_desel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && !adv && !selected) |=> ##1 !dq_oe);
endmodule

bind ztsram_top ztsram_chk #(.AW(AW), .NL(NL), .BW(BW)) u_chk (.*);

// File: tb/ztsram_top_test.sv
module ztsram_top_test;
  localparam int AW = 6, NL = 2, BW = 9, DW = NL * BW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, pipe_mode, lin_order, cs_a_n, cs_b, cs_c_n, adv, we, oe_n, dq_oe;
  logic [AW-1:0] addr;
  logic [NL-1:0] lane_we;
  logic [DW-1:0] dq_in, dq_out;

  ztsram_top #(.AW(AW), .NL(NL), .BW(BW)) uut (.*);

  int n_cmp = 0, n_bad = 0, cyc = 0;
  logic [DW-1:0] ref_mem [64];
  logic          h_v [4], h_w [4];
  logic [AW-1:0] h_a [4];
  logic [NL-1:0] h_l [4];
  string         h_t [4];
  logic          b_act, b_wr;
  logic [AW-1:0] b_base;
  logic [1:0]    b_cnt;

  function automatic logic [1:0] next_low(logic [1:0] lo, logic [1:0] n, logic lin);
    logic [2:0] s;
    s = {1'b0, lo} + {1'b0, n};
    return lin ? s[1:0] : (lo ^ n);
  endfunction

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] nw,
                                          logic [NL-1:0] ln);
    logic [DW-1:0] r;
    r = old;
    for (int j = 0; j < NL; j++) if (ln[j]) r[j*BW +: BW] = nw[j*BW +: BW];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s cycle %0d actual=%h expected=%h", req, cyc, act, exp);
    end
  endtask

  task automatic do_reset(input logic pm, input logic lo);
    rst_n = 1'b0; pipe_mode = pm; lin_order = lo;
    adv = 1'b0; we = 1'b0; cs_a_n = 1'b1; cs_b = 1'b0; cs_c_n = 1'b1;
    oe_n = 1'b0; addr = '0; lane_we = '0; dq_in = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(dq_oe == 1'b0, "R11", DW'(dq_oe), '0);
    for (int i = 0; i < 4; i++) h_v[i] = 1'b0;
    b_act = 1'b0; b_wr = 1'b0; b_base = '0; b_cnt = '0; cyc = 0;
  endtask

  // One command edge plus the data slot that falls on the same edge.
  task automatic step(input logic a_adv, input logic a_we, input logic a_sel,
                      input logic [AW-1:0] a_addr, input logic [NL-1:0] a_lanes,
                      input logic a_oe_n, input string tag);
    logic ov, ow; logic [AW-1:0] oa; logic [1:0] nc; int k, lat, si;
    logic [DW-1:0] d; string t;
    adv = a_adv; we = a_we; addr = a_addr; lane_we = a_lanes;
    k = $urandom_range(0, 2);
    cs_a_n = a_sel ? 1'b0 : (k == 0);
    cs_b   = a_sel ? 1'b1 : (k != 1);
    cs_c_n = a_sel ? 1'b0 : (k == 2);
    nc = b_cnt + 2'd1;
    if (!a_adv) begin ov = a_sel; ow = a_we; oa = a_addr; end
    else begin ov = b_act; ow = b_wr; oa = {b_base[AW-1:2], next_low(b_base[1:0], nc, lin_order)}; end
    t = tag;
    if (t == "") t = !ov ? "R1" : a_adv ? (lin_order ? "R7" : "R8") : (pipe_mode ? "R2" : "R4");
    h_v[cyc%4] = ov; h_w[cyc%4] = ow; h_a[cyc%4] = oa; h_l[cyc%4] = a_lanes; h_t[cyc%4] = t;
    lat = pipe_mode ? 2 : 1;
    d = DW'($urandom);
    dq_in = d;
    oe_n = a_oe_n;
    #1;
    if (cyc >= lat) begin
      si = (cyc - lat) % 4;
      if (h_v[si] && h_w[si]) begin
        ref_mem[h_a[si]] = merge(ref_mem[h_a[si]], d, h_l[si]);
        chk(dq_oe == 1'b0, h_t[si], DW'(dq_oe), '0);
      end else if (h_v[si] && !a_oe_n) begin
        chk(dq_oe == 1'b1, h_t[si], DW'(dq_oe), 1);
        chk(dq_out === ref_mem[h_a[si]], h_t[si], dq_out, ref_mem[h_a[si]]);
        if ($urandom_range(0, 3) == 0) begin
          oe_n = 1'b1; #1;
          chk(dq_oe == 1'b0, "R10", DW'(dq_oe), '0);
          oe_n = 1'b0;
        end
      end else begin
        chk(dq_oe == 1'b0, h_v[si] ? "R10" : h_t[si], DW'(dq_oe), '0);
      end
    end
    if (!a_adv) begin b_act = a_sel; b_wr = a_we; b_base = a_addr; b_cnt = '0; end
    else if (b_act) b_cnt = nc;
    @(posedge clk);
    @(negedge clk);
    cyc++;
  endtask

  task automatic directed();
    step(0, 1, 1, 6'd8,  2'b11, 0, "R3");
    step(0, 0, 1, 6'd8,  2'b00, 0, "R5");
    step(0, 1, 1, 6'd8,  2'b01, 0, "R6");
    step(0, 0, 1, 6'd8,  2'b00, 0, "R5");
    step(0, 1, 1, 6'd9,  2'b10, 0, "R6");
    step(0, 0, 1, 6'd9,  2'b00, 0, "R6");
    step(0, 0, 1, 6'd10, 2'b00, 0, "R4");
    step(0, 1, 1, 6'd11, 2'b11, 0, "R4");
    step(0, 0, 1, 6'd11, 2'b00, 0, "R4");
    step(0, 1, 1, 6'd10, 2'b11, 0, "R4");
    step(0, 1, 1, 6'd12, 2'b11, 0, "R9");
    step(0, 0, 0, 6'd12, 2'b00, 0, "R9");
    step(0, 0, 1, 6'd12, 2'b00, 0, "R9");
    step(0, 1, 1, 6'd14, 2'b11, 0, "R7");
    for (int i = 0; i < 3; i++) step(1, 0, 1, 6'd0, 2'b11, 0, lin_order ? "R7" : "R8");
    step(0, 0, 1, 6'd13, 2'b00, 0, lin_order ? "R7" : "R8");
    for (int i = 0; i < 4; i++) step(1, 1, 1, 6'd0, 2'b00, 0, lin_order ? "R7" : "R8");
  endtask

  initial begin
    void'($urandom(32'd7351));
    do_reset(1'b0, 1'b1);
    for (int a = 0; a < 64; a++) begin
      ref_mem[a] = '0;
      step(0, 1, 1, AW'(a), 2'b11, 0, "R3");
    end
    step(0, 0, 0, '0, '0, 0, "R9");
    step(0, 0, 0, '0, '0, 0, "R9");
    for (int m = 0; m < 4; m++) begin
      do_reset(m[1], m[0]);
      step(1, 0, 1, 6'd3, 2'b00, 0, "R11");
      step(1, 0, 1, 6'd3, 2'b00, 0, "R11");
      directed();
      for (int i = 0; i < 400; i++) begin
        logic [AW-1:0] ra;
        ra = ($urandom_range(0, 3) == 0) ? AW'($urandom) : {3'b101, 3'($urandom)};
        step($urandom_range(0, 9) < 3, $urandom_range(0, 1) == 1,
             $urandom_range(0, 19) < 17, ra, NL'($urandom),
             $urandom_range(0, 9) == 0, "");
      end
      step(0, 0, 0, '0, '0, 0, "R9");
      step(0, 0, 0, '0, '0, 0, "R9");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R4 watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule